// File: doc/BRIEF.md
# Bridge Configuration Register File

This block holds the 256-byte configuration header of a bridge between two PCI buses. It uses the type-1 header layout. A byte-wide access port carries five things: a function number, a register offset, write data, a write strobe and a read strobe. Only function zero exists. Each offset has its own policy: it stores the full byte, it stores the byte under a write mask, or it is read-only. At reset the header loads an image. The image is built from a 32-bit identity parameter and a variant parameter, and the variant picks between a plain bridge and a graphics-port bridge.

The secondary bus number can be written at any time. When that happens, the block signals on a sideband in the same cycle as the write, so that an external bus-routing table can follow the change. One pulse releases the bus number the bridge used to own. A second pulse claims the new bus number for this bridge's index.

Top module: `bridge_cfg_top`

## Requirements
- R1: An access with a nonzero function number changes no register. A read with a nonzero function number returns 0xFF.
- R2: Writes to these offsets are discarded: 0x00-0x03, 0x06-0x0B, 0x0E, 0x1E, 0x1F, 0x34, 0x3D, 0x67, 0xDC-0xE3.
- R3: A write to a masked offset stores only `data & mask`, and bits outside the mask read as 0. The masks are:
  - 0x04: 0x67
  - 0x05: 0x03
  - 0x1C, 0x1D, 0x20, 0x22, 0x24, 0x26: 0xF0
  - 0x3E: 0xEF
  - 0x3F: 0x0F
  - 0x40: 0x32
  - 0x41: 0x07
  - 0x43: 0x03
  - 0x64: 0x7E
  - 0x69: 0x3F
- R4: At reset the identity word ID loads bytes 0 to 3 as follows:
  - offset 0x00: ID[23:16]
  - offset 0x01: ID[31:24]
  - offset 0x02: ID[7:0]
  - offset 0x03: ID[15:8]
- R5: For both variants, reset loads 0x04 at 0x0A, 0x06 at 0x0B, 0x01 at 0x0E and 0x02 at 0x1F.
- R6: For the plain variant (VARIANT=0), reset loads the following:
  - 0x80 at 0x06 and at 0x1E
  - 0x02 at 0x07 and at 0x43
  - 0x01 at 0x1C, 0x1D, 0x24, 0x26, 0xDC and 0xDE
  - 0xDC at 0x34
- R7: For the graphics-port variant (VARIANT=1), reset loads the following:
  - 0xF0 at 0x1C, 0x20 and 0x24
  - 0xA0 at 0x1E
  - 0xFF at 0x21 and 0x25
- R8: A function-0 write to offset 0x19 pulses `busUnmapStb` for one cycle, in the cycle of the write, with `busUnmapNum` equal to the previous value. This happens only when the previous value was nonzero.
- R9: A function-0 write to offset 0x19 pulses `busMapStb` for one cycle, in the cycle of the write, with `busMapNum` equal to the new value and `busMapIdx` equal to BRIDGE_INDEX. This happens only when the new value is nonzero. No other access pulses either strobe.
- R10: Offsets not named in R4-R7 reset to 0x00. Writable offsets without a mask, 0x19 among them, store the full byte.
- R11: `rdData` and `rdValid` are registered. They are valid in the cycle after the read strobe, and `rdValid` is low in any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| funcNum | input | FUNC_W | Function number of the access |
| regOffset | input | 8 | Register offset |
| wrData | input | 8 | Write data |
| wrStb | input | 1 | Write strobe |
| rdStb | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | Read data valid, one cycle after rdStb |
| busUnmapStb | output | 1 | Release the old secondary bus number |
| busUnmapNum | output | 8 | Bus number being released |
| busMapStb | output | 1 | Claim the new secondary bus number |
| busMapNum | output | 8 | Bus number being claimed |
| busMapIdx | output | 8 | Bridge index bound to the claimed bus |

## Verification
The hardest state to reach is a secondary bus rewrite while the old number is nonzero. In that single cycle both sideband pulses must fire, carrying two different numbers. The bench sets up that state by first writing a nonzero number, then writing a second nonzero number, and finally writing zero. It checks the strobes combinationally within the write cycle. Writes with a nonzero function number and writes to other offsets are also driven, and the bench confirms that neither kind produces a pulse. Both variants are instantiated side by side on the same stimulus, so every read compares two reset images at once.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

  localparam int CFG_DEPTH = 256;
  localparam int OFF_W     = $clog2(CFG_DEPTH);
  localparam logic [OFF_W-1:0] SEC_BUS_OFF = 8'h19;

  typedef enum logic {
    BRG_PLAIN = 1'b0,
    BRG_GFX   = 1'b1
  } brgVariant_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;    // function-0 write
    logic             rdEn;    // function-0 read
    logic             rdNull;  // read of an absent function
    logic [OFF_W-1:0] offset;
    logic [7:0]       data;
  } cfgStrobe_t;

  function automatic logic isReadOnly(input logic [OFF_W-1:0] off);
    case (off) inside
      [8'h00:8'h03], [8'h06:8'h0B], 8'h0E, 8'h1E, 8'h1F,
      8'h34, 8'h3D, 8'h67, [8'hDC:8'hE3]: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] writeMask(input logic [OFF_W-1:0] off);
    case (off)
      8'h04: return 8'h67;
      8'h05: return 8'h03;
      8'h1C, 8'h1D, 8'h20, 8'h22, 8'h24, 8'h26: return 8'hF0;
      8'h3E: return 8'hEF;
      8'h3F: return 8'h0F;
      8'h40: return 8'h32;
      8'h41: return 8'h07;
      8'h43: return 8'h03;
      8'h64: return 8'h7E;
      8'h69: return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] resetByte(input logic [OFF_W-1:0] off,
                                           input logic [31:0] idWord,
                                           input brgVariant_e variant);
    logic [7:0] val;
    val = 8'h00;
    case (off)
      8'h00: val = idWord[23:16];
      8'h01: val = idWord[31:24];
      8'h02: val = idWord[7:0];
      8'h03: val = idWord[15:8];
      8'h0A: val = 8'h04;
      8'h0B: val = 8'h06;
      8'h0E: val = 8'h01;
      8'h1F: val = 8'h02;
      default: val = 8'h00;
    endcase
    if (variant == BRG_PLAIN) begin
      case (off)
        8'h06, 8'h1E: val = 8'h80;
        8'h07, 8'h43: val = 8'h02;
        8'h1C, 8'h1D, 8'h24, 8'h26, 8'hDC, 8'hDE: val = 8'h01;
        8'h34: val = 8'hDC;
        default: ;
      endcase
    end else begin
      case (off)
        8'h1C, 8'h20, 8'h24: val = 8'hF0;
        8'h1E: val = 8'hA0;
        8'h21, 8'h25: val = 8'hFF;
        default: ;
      endcase
    end
    return val;
  endfunction

endpackage

// File: rtl/bridge_cfg_ctrl.sv
module bridge_cfg_ctrl
  import bridge_cfg_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter logic [7:0] BRIDGE_INDEX = 8'd1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FUNC_W-1:0]  funcNum,
  input  logic [OFF_W-1:0]   regOffset,
  input  logic [7:0]         wrData,
  input  logic               wrStb,
  input  logic               rdStb,
  input  logic [7:0]         secBusNow,
  output cfgStrobe_t         strb,
  output logic               busUnmapStb,
  output logic [7:0]         busUnmapNum,
  output logic               busMapStb,
  output logic [7:0]         busMapNum,
  output logic [7:0]         busMapIdx
);

  logic funcOk;
  logic secBusWrite;

  assign funcOk = (funcNum == '0);

  always_comb begin
    strb.wrEn   = wrStb && funcOk;
    strb.rdEn   = rdStb && funcOk;
    strb.rdNull = rdStb && !funcOk;
    strb.offset = regOffset;
    strb.data   = wrData;
  end

  assign secBusWrite = strb.wrEn && (regOffset == SEC_BUS_OFF);

  always_comb begin
    busUnmapStb = secBusWrite && (secBusNow != 8'h00);
    busUnmapNum = secBusNow;
    busMapStb   = secBusWrite && (wrData != 8'h00);
    busMapNum   = wrData;
    busMapIdx   = BRIDGE_INDEX;
  end

  AST_UNMAP_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    busUnmapStb |-> busUnmapNum != 8'h00); // R8
  AST_MAP_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    busMapStb |-> busMapNum != 8'h00); // R9
  AST_SECBUS_STORED: assert property (@(posedge clk) disable iff (!rstN)
    secBusWrite |=> secBusNow == $past(wrData)); // R10
  AST_MAP_TRACKS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    busMapStb |=> secBusNow == $past(busMapNum)); // R9

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bridge_cfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'hA5C3_1E7B,
  parameter brgVariant_e VARIANT = BRG_PLAIN
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strb,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic [7:0] secBusNow
);

  logic [7:0] cfgMem [CFG_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CFG_DEPTH; i++)
        cfgMem[i] <= resetByte(OFF_W'(i), ID_WORD, VARIANT);
    end else if (strb.wrEn && !isReadOnly(strb.offset)) begin
      cfgMem[strb.offset] <= strb.data & writeMask(strb.offset);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 8'h00;
    end else begin
      rdValid <= strb.rdEn || strb.rdNull;
      if (strb.rdEn)        rdData <= cfgMem[strb.offset];
      else if (strb.rdNull) rdData <= 8'hFF;
    end
  end

  assign secBusNow = cfgMem[SEC_BUS_OFF];

  AST_RO_CAP_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.offset == 8'h34) |=> $stable(cfgMem[8'h34])); // R2
  AST_CMD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.offset == 8'h04) |=> (cfgMem[8'h04] & 8'h98) == 8'h00); // R3
  AST_RD_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn && strb.rdNull)); // R1

endmodule

// File: rtl/bridge_cfg_top.sv
module bridge_cfg_top
  import bridge_cfg_pkg::*;
#(
  parameter int          FUNC_W       = 3,
  parameter logic [31:0] ID_WORD      = 32'hA5C3_1E7B,
  parameter brgVariant_e VARIANT      = BRG_PLAIN,
  parameter logic [7:0]  BRIDGE_INDEX = 8'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FUNC_W-1:0] funcNum,
  input  logic [7:0]        regOffset,
  input  logic [7:0]        wrData,
  input  logic              wrStb,
  input  logic              rdStb,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busUnmapStb,
  output logic [7:0]        busUnmapNum,
  output logic              busMapStb,
  output logic [7:0]        busMapNum,
  output logic [7:0]        busMapIdx
);

  cfgStrobe_t strb;
  logic [7:0] secBusNow;

  bridge_cfg_ctrl #(.FUNC_W(FUNC_W), .BRIDGE_INDEX(BRIDGE_INDEX)) u_ctrl (
    .clk(clk), .rstN(rstN), .funcNum(funcNum), .regOffset(regOffset),
    .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb), .secBusNow(secBusNow),
    .strb(strb), .busUnmapStb(busUnmapStb), .busUnmapNum(busUnmapNum),
    .busMapStb(busMapStb), .busMapNum(busMapNum), .busMapIdx(busMapIdx)
  );

  bridge_cfg_regs #(.ID_WORD(ID_WORD), .VARIANT(VARIANT)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdData(rdData), .rdValid(rdValid), .secBusNow(secBusNow)
  );

  AST_ABSENT_FUNC_FF: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && funcNum != '0) |=> (rdValid && rdData == 8'hFF)); // R1
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> !rdValid); // R11

endmodule

// File: tb/bridge_cfg_top_tb.sv
module bridge_cfg_top_tb;
  import bridge_cfg_pkg::*;

  typedef struct {
    logic [7:0] expPlain;
    logic [7:0] expGfx;
    string      tag;
  } rdItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] funcNum = '0;
  logic [7:0] regOffset = '0;
  logic [7:0] wrData = '0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;

  logic [7:0] rdData, rdDataG, unNum, mNum, mIdx, unNumG, mNumG, mIdxG;
  logic       rdValid, rdValidG, unStb, mStb, unStbG, mStbG;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  rdItem_t expQ[$];

  always #5 clk = ~clk;

  bridge_cfg_top #(.ID_WORD(32'h1234_5678), .VARIANT(BRG_PLAIN), .BRIDGE_INDEX(8'd3)) u_dut (
    .clk(clk), .rstN(rstN), .funcNum(funcNum), .regOffset(regOffset),
    .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb), .rdData(rdData),
    .rdValid(rdValid), .busUnmapStb(unStb), .busUnmapNum(unNum),
    .busMapStb(mStb), .busMapNum(mNum), .busMapIdx(mIdx));

  bridge_cfg_top #(.ID_WORD(32'h9ABC_DEF0), .VARIANT(BRG_GFX), .BRIDGE_INDEX(8'd4)) u_dut_gfx (
    .clk(clk), .rstN(rstN), .funcNum(funcNum), .regOffset(regOffset),
    .wrData(wrData), .wrStb(wrStb), .rdStb(rdStb), .rdData(rdDataG),
    .rdValid(rdValidG), .busUnmapStb(unStbG), .busUnmapNum(unNumG),
    .busMapStb(mStbG), .busMapNum(mNumG), .busMapIdx(mIdxG));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pop one expectation per valid read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R11 unexpected rdValid", 8'h01, 8'h00);
      end else begin
        rdItem_t it;
        it = expQ.pop_front();
        check({it.tag, " plain"}, rdData, it.expPlain);
        check({it.tag, " gfx"}, rdDataG, it.expGfx);
      end
    end
  end

  task automatic doRead(input logic [7:0] off, input logic [2:0] fn,
                        input logic [7:0] ep, input logic [7:0] eg, input string tag);
    rdItem_t it;
    it.expPlain = ep; it.expGfx = eg; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    funcNum = fn; regOffset = off; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0; funcNum = '0;
    check("R11 rdValid after strobe", {7'd0, rdValid}, 8'h01);
  endtask

  task automatic doWrite(input logic [7:0] off, input logic [7:0] val, input logic [2:0] fn);
    @(negedge clk);
    funcNum = fn; regOffset = off; wrData = val; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; funcNum = '0;
  endtask

  // write with combinational sideband check in the write cycle (plain instance)
  task automatic busWrite(input logic [7:0] val, input logic [2:0] fn, input logic [7:0] off,
                          input logic eUn, input logic [7:0] eUnNum,
                          input logic eMap, input logic [7:0] eMapNum);
    @(negedge clk);
    funcNum = fn; regOffset = off; wrData = val; wrStb = 1'b1;
    #1;
    check("R8 unmap strobe", {7'd0, unStb}, {7'd0, eUn});
    if (eUn) check("R8 unmap number", unNum, eUnNum);
    check("R9 map strobe", {7'd0, mStb}, {7'd0, eMap});
    if (eMap) begin
      check("R9 map number", mNum, eMapNum);
      check("R9 map index", mIdx, 8'd3);
    end
    @(negedge clk);
    wrStb = 1'b0; funcNum = '0;
    #1;
    check("R8 unmap one cycle", {7'd0, unStb}, 8'h00);
    check("R9 map one cycle", {7'd0, mStb}, 8'h00);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 reset rdValid low", {7'd0, rdValid}, 8'h00);
    check("R9 reset no map", {7'd0, mStb}, 8'h00);

    // R4 identity order
    doRead(8'h00, 0, 8'h34, 8'hBC, "R4 off00");
    doRead(8'h01, 0, 8'h12, 8'h9A, "R4 off01");
    doRead(8'h02, 0, 8'h78, 8'hF0, "R4 off02");
    doRead(8'h03, 0, 8'h56, 8'hDE, "R4 off03");
    // R5 common
    doRead(8'h0A, 0, 8'h04, 8'h04, "R5 subclass");
    doRead(8'h0B, 0, 8'h06, 8'h06, "R5 class");
    doRead(8'h0E, 0, 8'h01, 8'h01, "R5 header");
    doRead(8'h1F, 0, 8'h02, 8'h02, "R5 off1F");
    // R6 / R7 variant images
    doRead(8'h06, 0, 8'h80, 8'h00, "R6 R7 off06");
    doRead(8'h07, 0, 8'h02, 8'h00, "R6 R7 off07");
    doRead(8'h1C, 0, 8'h01, 8'hF0, "R6 R7 off1C");
    doRead(8'h1D, 0, 8'h01, 8'h00, "R6 R7 off1D");
    doRead(8'h1E, 0, 8'h80, 8'hA0, "R6 R7 off1E");
    doRead(8'h20, 0, 8'h00, 8'hF0, "R6 R7 off20");
    doRead(8'h21, 0, 8'h00, 8'hFF, "R6 R7 off21");
    doRead(8'h24, 0, 8'h01, 8'hF0, "R6 R7 off24");
    doRead(8'h25, 0, 8'h00, 8'hFF, "R6 R7 off25");
    doRead(8'h26, 0, 8'h01, 8'h00, "R6 R7 off26");
    doRead(8'h34, 0, 8'hDC, 8'h00, "R6 off34");
    doRead(8'h43, 0, 8'h02, 8'h00, "R6 off43");
    doRead(8'hDC, 0, 8'h01, 8'h00, "R6 offDC");
    doRead(8'hDE, 0, 8'h01, 8'h00, "R6 offDE");
    // R10 default zero and full-byte store
    doRead(8'h50, 0, 8'h00, 8'h00, "R10 reset zero");
    doWrite(8'h50, 8'hA5, 0);
    doRead(8'h50, 0, 8'hA5, 8'hA5, "R10 full byte");
    // R2 read-only
    doWrite(8'h00, 8'hFF, 0);
    doWrite(8'h34, 8'h00, 0);
    doWrite(8'hE3, 8'h55, 0);
    doWrite(8'h67, 8'hFF, 0);
    doWrite(8'h0A, 8'hFF, 0);
    doRead(8'h00, 0, 8'h34, 8'hBC, "R2 off00");
    doRead(8'h34, 0, 8'hDC, 8'h00, "R2 off34");
    doRead(8'hE3, 0, 8'h00, 8'h00, "R2 offE3");
    doRead(8'h67, 0, 8'h00, 8'h00, "R2 off67");
    doRead(8'h0A, 0, 8'h04, 8'h04, "R2 off0A");
    // R3 masks
    doWrite(8'h04, 8'hFF, 0); doRead(8'h04, 0, 8'h67, 8'h67, "R3 off04");
    doWrite(8'h05, 8'hFF, 0); doRead(8'h05, 0, 8'h03, 8'h03, "R3 off05");
    doWrite(8'h1C, 8'hFF, 0); doRead(8'h1C, 0, 8'hF0, 8'hF0, "R3 off1C");
    doWrite(8'h22, 8'hAB, 0); doRead(8'h22, 0, 8'hA0, 8'hA0, "R3 off22");
    doWrite(8'h3E, 8'hFF, 0); doRead(8'h3E, 0, 8'hEF, 8'hEF, "R3 off3E");
    doWrite(8'h3F, 8'hFF, 0); doRead(8'h3F, 0, 8'h0F, 8'h0F, "R3 off3F");
    doWrite(8'h40, 8'hFF, 0); doRead(8'h40, 0, 8'h32, 8'h32, "R3 off40");
    doWrite(8'h41, 8'hFF, 0); doRead(8'h41, 0, 8'h07, 8'h07, "R3 off41");
    doWrite(8'h43, 8'hFF, 0); doRead(8'h43, 0, 8'h03, 8'h03, "R3 off43");
    doWrite(8'h64, 8'hFF, 0); doRead(8'h64, 0, 8'h7E, 8'h7E, "R3 off64");
    doWrite(8'h69, 8'hFF, 0); doRead(8'h69, 0, 8'h3F, 8'h3F, "R3 off69");
    // R1 absent function
    doWrite(8'h50, 8'h00, 3'd1);
    doRead(8'h50, 3'd1, 8'hFF, 8'hFF, "R1 read func1");
    doRead(8'h00, 3'd7, 8'hFF, 8'hFF, "R1 read func7");
    doRead(8'h50, 0, 8'hA5, 8'hA5, "R1 func1 write ignored");
    // R8 / R9 secondary bus sideband
    busWrite(8'h05, 0, 8'h19, 1'b0, 8'h00, 1'b1, 8'h05);
    busWrite(8'h09, 0, 8'h19, 1'b1, 8'h05, 1'b1, 8'h09);
    busWrite(8'h77, 3'd2, 8'h19, 1'b0, 8'h00, 1'b0, 8'h00);
    busWrite(8'h33, 0, 8'h18, 1'b0, 8'h00, 1'b0, 8'h00);
    doRead(8'h19, 0, 8'h09, 8'h09, "R10 secondary bus stored");
    busWrite(8'h00, 0, 8'h19, 1'b1, 8'h09, 1'b0, 8'h00);
    doRead(8'h19, 0, 8'h00, 8'h00, "R10 secondary bus cleared");

    repeat (3) @(negedge clk);
    check("R11 queue drained", 8'(expQ.size()), 8'h00);
    check("R11 idle rdValid low", {7'd0, rdValid}, 8'h00);
    finishRun();
  end

endmodule